// File: doc/BRIEF.md
# Cache Line Refill Engine with Early Processor Release

The block refills one cache line of `WORDS` words (8 by default) after a miss. It accepts a word address and an ordering mode, issues one word request at a time to a word-serial memory port, and writes each returned word into the line buffer through a one-hot write strobe at the word's own offset. The stalled processor does not wait for the whole line: the missed word is handed over on a single-cycle valid pulse in the very cycle memory returns it.

Two orderings are offered. With the wrapped ordering the missed word is fetched first and the rest follow, wrapping modulo the line size. With the linear ordering words are fetched from offset 0 upward, and the processor is released when the missed word appears in that stream while the remaining words keep filling. A per-word filled mask tracks completion, a one-cycle line-complete pulse marks the end of the refill, and no new miss is taken until then.

Top module: `line_refill_engine`

## Requirements
- R1: After reset the engine is idle: `miss_ready_o` is 1 and `mem_req_o`, `lb_we_o`, `cpu_valid_o` and `line_done_o` are all 0.
- R2: With `mode_i` = 1 (wrapped), the k-th word request of a miss (k = 0..7) addresses line base plus ((c + k) mod 8), where c is the low 3 bits of `miss_addr_i` and the line base is `miss_addr_i` with those 3 bits cleared; the missed word is therefore requested first.
- R3: With `mode_i` = 0 (linear), the k-th word request addresses line base plus k, starting at offset 0.
- R4: Each returned word (cycle with `mem_rvalid_i` = 1 while a request is outstanding) raises exactly bit i of `lb_we_o` in that same cycle, where i is the offset of the word it answers, and `lb_wdata_o` carries the returned data; `lb_we_o` is 0 in every other cycle.
- R5: In wrapped mode `cpu_valid_o` pulses, with `cpu_data_o` equal to the returned data, in the same cycle the missed word returns, which is the first response of the refill.
- R6: In linear mode `cpu_valid_o` pulses in the cycle the word at the missed offset returns, and the words after it are still requested and written.
- R7: `cpu_valid_o` is high in exactly one cycle per miss.
- R8: `line_done_o` is high for exactly one cycle, the cycle after the write of the last of the 8 words; `miss_ready_o` returns to 1 in the cycle after that.
- R9: While a refill is in progress `miss_ready_o` is 0 and `miss_valid_i`, `miss_addr_i` and `mode_i` have no effect on the request sequence of the refill in progress.
- R10: A request not granted (`mem_req_o` = 1, `mem_gnt_i` = 0) stays asserted with the same `mem_addr_o` in the next cycle.
- R11: At most one word request is outstanding: `mem_req_o` is 0 from a grant until the matching response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request, taken when `miss_ready_o` is 1 |
| miss_addr_i | input | ADDR_W | Word address of the missed word |
| mode_i | input | 1 | 1 = wrapped missed-word-first, 0 = linear from offset 0 |
| miss_ready_o | output | 1 | Engine idle and able to take a miss |
| mem_req_o | output | 1 | Word request to memory |
| mem_addr_o | output | ADDR_W | Word address of the request |
| mem_gnt_i | input | 1 | Memory accepts the current request |
| mem_rvalid_i | input | 1 | Memory returns the outstanding word |
| mem_rdata_i | input | DATA_W | Returned word |
| lb_we_o | output | WORDS | One-hot line buffer word write strobe |
| lb_wdata_o | output | DATA_W | Line buffer write data |
| cpu_valid_o | output | 1 | Missed word delivered to the processor |
| cpu_data_o | output | DATA_W | Missed word data |
| line_done_o | output | 1 | Whole line filled (one-cycle pulse) |

## Verification
On every cycle the assertions hold the memory handshake rules (a held request keeps its address, one request at a time, no requests while idle), the one-hot shape of the write strobe and its tie to a response, and the single processor release per miss counted against the line-complete pulse. Only the bench scenarios show that the request order matches the chosen mode for each missed offset, including the wrap at offsets 0 and 7, that each word lands at the right offset with the right data, and that misses offered mid-refill leave the sequence untouched.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } refill_state_e;

  typedef enum logic {
    MODE_LINEAR  = 1'b0,
    MODE_WRAPPED = 1'b1
  } refill_mode_e;
endpackage

// File: rtl/refill_order.sv
// Maps the k-th step of a refill to a word offset within the line.
module refill_order #(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  refill_pkg::refill_mode_e mode_i,
  input  logic [OFF_W-1:0]         crit_i,
  input  logic [OFF_W-1:0]         step_i,
  output logic [OFF_W-1:0]         idx_o
);
  import refill_pkg::*;

  logic [OFF_W-1:0] wrapped;

  // WORDS is a power of two: truncation gives the modulo
  assign wrapped = OFF_W'(crit_i + step_i);
  assign idx_o   = (mode_i == MODE_WRAPPED) ? wrapped : step_i;
endmodule

// File: rtl/refill_fill_mask.sv
module refill_fill_mask #(
  parameter int WORDS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [WORDS-1:0] set_i,
  output logic [WORDS-1:0] mask_o,
  output logic             full_next_o
);
  logic [WORDS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (clear_i) mask_q <= '0;
    else              mask_q <= mask_q | set_i;
  end

  assign mask_o      = mask_q;
  assign full_next_o = &(mask_q | set_i);
endmodule

// File: rtl/refill_strobe_dec.sv
module refill_strobe_dec #(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             en_i,
  input  logic [OFF_W-1:0] idx_i,
  output logic [WORDS-1:0] we_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_we
    assign we_o[w] = en_i && (idx_i == OFF_W'(w));
  end
endmodule

// File: rtl/line_refill_engine.sv
module line_refill_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              mode_i,
  output logic              miss_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [WORDS-1:0]  lb_we_o,
  output logic [DATA_W-1:0] lb_wdata_o,
  output logic              cpu_valid_o,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              line_done_o
);
  import refill_pkg::*;

  refill_state_e    state_q, state_d;
  refill_mode_e     mode_q;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  crit_q;
  logic [OFF_W:0]    req_cnt_q;
  logic [OFF_W-1:0]  rsp_cnt_q;
  logic              out_q;

  logic              accept;
  logic              req_fire;
  logic              rsp_fire;
  logic [OFF_W-1:0]  req_idx;
  logic [OFF_W-1:0]  rsp_idx;
  logic [WORDS-1:0]  fill_mask;
  logic              full_next;

  assign accept   = miss_valid_i && (state_q == ST_IDLE);
  assign mem_req_o = (state_q == ST_FILL) && !out_q && !req_cnt_q[OFF_W];
  assign req_fire = mem_req_o && mem_gnt_i;
  assign rsp_fire = (state_q == ST_FILL) && out_q && mem_rvalid_i;

  refill_order #(.WORDS(WORDS)) u_req_order (
    .mode_i (mode_q),
    .crit_i (crit_q),
    .step_i (req_cnt_q[OFF_W-1:0]),
    .idx_o  (req_idx)
  );

  // responses come back in request order, so the same mapping applies
  refill_order #(.WORDS(WORDS)) u_rsp_order (
    .mode_i (mode_q),
    .crit_i (crit_q),
    .step_i (rsp_cnt_q),
    .idx_o  (rsp_idx)
  );

  refill_strobe_dec #(.WORDS(WORDS)) u_we_dec (
    .en_i  (rsp_fire),
    .idx_i (rsp_idx),
    .we_o  (lb_we_o)
  );

  refill_fill_mask #(.WORDS(WORDS)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept),
    .set_i       (lb_we_o),
    .mask_o      (fill_mask),
    .full_next_o (full_next)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (miss_valid_i) state_d = ST_FILL;
      ST_FILL: if (rsp_fire && full_next) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= MODE_LINEAR;
      base_q    <= '0;
      crit_q    <= '0;
      req_cnt_q <= '0;
      rsp_cnt_q <= '0;
      out_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q    <= refill_mode_e'(mode_i);
        base_q    <= miss_addr_i[ADDR_W-1:OFF_W];
        crit_q    <= miss_addr_i[OFF_W-1:0];
        req_cnt_q <= '0;
        rsp_cnt_q <= '0;
        out_q     <= 1'b0;
      end else begin
        if (req_fire) begin
          req_cnt_q <= req_cnt_q + 1'b1;
          out_q     <= 1'b1;
        end
        if (rsp_fire) begin
          rsp_cnt_q <= rsp_cnt_q + 1'b1;
          out_q     <= 1'b0;
        end
      end
    end
  end

  assign miss_ready_o = (state_q == ST_IDLE);
  assign mem_addr_o   = {base_q, req_idx};
  assign lb_wdata_o   = mem_rdata_i;
  assign cpu_valid_o  = rsp_fire && (rsp_idx == crit_q);
  assign cpu_data_o   = mem_rdata_i;
  assign line_done_o  = (state_q == ST_DONE) && (&fill_mask);
endmodule

// File: rtl/line_refill_engine_chk.sv
module line_refill_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic              miss_ready_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_gnt_i,
  input logic              mem_rvalid_i,
  input logic [WORDS-1:0]  lb_we_o,
  input logic              cpu_valid_o,
  input logic              line_done_o
);
  logic [3:0] cpu_cnt_q;
  logic       pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_cnt_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (miss_valid_i && miss_ready_o) cpu_cnt_q <= '0;
      else if (cpu_valid_o)             cpu_cnt_q <= cpu_cnt_q + 1'b1;
      if (mem_req_o && mem_gnt_i) pend_q <= 1'b1;
      else if (mem_rvalid_i)      pend_q <= 1'b0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ready_o |-> (!mem_req_o && lb_we_o == '0 && !cpu_valid_o));

  p_we_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lb_we_o));

  p_we_needs_rsp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_we_o != '0) |-> mem_rvalid_i);

  p_cpu_with_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_o |-> ($countones(lb_we_o) == 1));

  p_cpu_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_o |-> (cpu_cnt_q == 4'd0));

  p_cpu_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> (cpu_cnt_q == 4'd1));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> (!line_done_o && miss_ready_o));

  p_done_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_done_o) |-> ($past(lb_we_o) != '0));

  p_busy_not_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !miss_ready_o);

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_one_outstanding_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !mem_req_o);
endmodule

bind line_refill_engine line_refill_engine_chk #(
  .ADDR_W(ADDR_W),
  .WORDS (WORDS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .miss_valid_i (miss_valid_i),
  .miss_ready_o (miss_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_rvalid_i (mem_rvalid_i),
  .lb_we_o      (lb_we_o),
  .cpu_valid_o  (cpu_valid_o),
  .line_done_o  (line_done_o)
);

// File: tb/line_refill_engine_tb.sv
module line_refill_engine_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          miss_valid_i = 1'b0;
  logic [AW-1:0] miss_addr_i = '0;
  logic          mode_i = 1'b0;
  logic          miss_ready_o;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_gnt_i = 1'b0;
  logic          mem_rvalid_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [NW-1:0] lb_we_o;
  logic [DW-1:0] lb_wdata_o;
  logic          cpu_valid_o;
  logic [DW-1:0] cpu_data_o;
  logic          line_done_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  line_refill_engine #(.ADDR_W(AW), .DATA_W(DW), .WORDS(NW)) u_dut (
    .clk_i, .rst_ni, .miss_valid_i, .miss_addr_i, .mode_i, .miss_ready_o,
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .lb_we_o, .lb_wdata_o, .cpu_valid_o, .cpu_data_o, .line_done_o
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [AW-1:0] exp_req(input logic [AW-1:0] miss,
                                            input logic m, input int k);
    logic [2:0] off;
    off = m ? 3'(miss[2:0] + 3'(k)) : 3'(k);
    return {miss[AW-1:3], off};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_miss(input logic [AW-1:0] a, input logic m, input bit poke);
    int ordk = 0, rk = 0, cpu_seen = 0, lat = 0;
    bit pend = 0, prev_gnt = 0, prev_rv = 0, prev_req = 0;
    logic [AW-1:0] pa = '0, prev_addr = '0, gnt_addr = '0;
    logic [2:0] idx;
    bit exp_cpu;
    string mreq;
    mreq = m ? "R5" : "R6";
    @(negedge clk_i);
    while (!miss_ready_o) @(negedge clk_i);
    miss_valid_i = 1'b1; miss_addr_i = a; mode_i = m;
    @(negedge clk_i);
    miss_valid_i = 1'b0; miss_addr_i = ~a; mode_i = ~m;
    chk(miss_ready_o == 1'b0, "R9", "ready while busy", 64'(miss_ready_o), 0);
    for (int g = 0; g < 400; g++) begin
      if (prev_gnt) begin pend = 1; pa = gnt_addr; lat = $urandom_range(0, 3); end
      if (prev_rv) begin pend = 0; rk++; end
      if (rk == NW) begin
        miss_valid_i = 1'b0;
        mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0;
        chk(line_done_o == 1'b1, "R8", "line_done after last word", 64'(line_done_o), 1);
        chk(cpu_seen == 1, "R7", "cpu_valid count", 64'(cpu_seen), 1);
        @(negedge clk_i);
        chk(line_done_o == 1'b0 && miss_ready_o == 1'b1, "R8", "done pulse end / ready",
            {62'b0, line_done_o, miss_ready_o}, 64'b01);
        return;
      end
      chk(line_done_o == 1'b0, "R8", "early line_done", 64'(line_done_o), 0);
      if (poke) begin
        miss_valid_i = 1'($urandom_range(0, 1));
        miss_addr_i  = $urandom;
        mode_i       = 1'($urandom_range(0, 1));
        chk(miss_ready_o == 1'b0, "R9", "ready during refill", 64'(miss_ready_o), 0);
      end
      if (prev_req && !prev_gnt)
        chk(mem_req_o && mem_addr_o == prev_addr, "R10", "held request",
            {31'b0, mem_req_o, mem_addr_o}, {32'b1, prev_addr});
      prev_req = mem_req_o; prev_addr = mem_addr_o;
      mem_rvalid_i = 1'b0; mem_gnt_i = 1'b0;
      if (pend) begin
        chk(!mem_req_o, "R11", "request while outstanding", 64'(mem_req_o), 0);
        if (lat == 0) begin
          mem_rvalid_i = 1'b1; mem_rdata_i = mem_word(pa);
        end else lat--;
      end else if (mem_req_o) begin
        chk(ordk < NW && mem_addr_o == exp_req(a, m, ordk), m ? "R2" : "R3",
            "request address", 64'(mem_addr_o), 64'(exp_req(a, m, ordk)));
        mem_gnt_i = 1'($urandom_range(0, 1));
        if (mem_gnt_i) begin ordk++; gnt_addr = mem_addr_o; end
      end
      prev_gnt = mem_gnt_i; prev_rv = mem_rvalid_i;
      #1;
      if (mem_rvalid_i) begin
        idx = pa[2:0];
        chk(lb_we_o == NW'(1) << idx && lb_wdata_o == mem_word(pa), "R4", "write strobe/data",
            {24'b0, lb_we_o, lb_wdata_o}, {24'b0, NW'(1) << idx, mem_word(pa)});
        exp_cpu = (idx == a[2:0]);
        chk(cpu_valid_o == exp_cpu, mreq, "cpu_valid", 64'(cpu_valid_o), 64'(exp_cpu));
        if (cpu_valid_o) begin
          cpu_seen++;
          chk(cpu_data_o == mem_word(pa), mreq, "cpu_data", 64'(cpu_data_o), 64'(mem_word(pa)));
          if (m) chk(rk == 0, "R5", "missed word first response", 64'(rk), 0);
        end
      end else begin
        chk(lb_we_o == '0 && cpu_valid_o == 1'b0, "R4", "idle strobes",
            {55'b0, cpu_valid_o, lb_we_o}, 0);
      end
      @(negedge clk_i);
    end
    chk(1'b0, "R8", "refill watchdog", 64'(rk), NW);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    #1;
    chk(miss_ready_o && !mem_req_o && lb_we_o == '0 && !cpu_valid_o && !line_done_o,
        "R1", "reset state", {59'b0, miss_ready_o, mem_req_o, |lb_we_o, cpu_valid_o, line_done_o},
        64'b10000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(miss_ready_o && !mem_req_o, "R1", "idle after reset", {62'b0, miss_ready_o, mem_req_o}, 2);
    run_miss(32'h0000_1235, 1'b1, 1'b0);  // wrap from 5
    run_miss(32'h0000_2040, 1'b1, 1'b0);  // missed word at offset 0
    run_miss(32'h0000_3107, 1'b1, 1'b1);  // offset 7 wraps at once, mid-refill misses
    run_miss(32'h0000_4000, 1'b0, 1'b0);  // linear, release on first word
    run_miss(32'h0000_500F, 1'b0, 1'b0);  // linear, release on last word
    run_miss(32'h0000_6013, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++)
      run_miss($urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule